// File: doc/BRIEF.md
# Iterative Floating-Point Divider

This block divides one floating-point number by another in a compact custom format that has no NaN encodings and no subnormals. A request is a single-cycle `start` together with a dividend and a divisor. Operand pairs that involve a zero or an infinity are settled straight away from a small decision table. Every other pair goes through a restoring radix-2 significand divider that yields one quotient bit per clock. A final cycle then normalises, rounds and packs the result.

The block is intended as an arithmetic operator inside a statically scheduled datapath. For that reason its latency is fixed and known ahead of time: one cycle for a special operand pair, and `WMAN+4` cycles for an ordinary one. Cases that would be undefined, or that would trap in other arithmetic, return a defined value and raise `err` instead. Outputs hold their value until the next completion.

Top module: `fdiv_iter`

## Requirements
- R1: A word is {sign at bit W-1, a WEXP-bit biased exponent with bias 2^(WEXP-1)-1, then WMAN fraction bits with an implicit leading one}, where W = 1+WEXP+WMAN. Exponent field 0 means zero and exponent field all-ones means infinity; in both cases the input fraction is ignored. Results never carry a negative zero, a nonzero fraction alongside exponent 0, or a nonzero fraction alongside an all-ones exponent.
- R2: When both operands are finite and nonzero, the quotient sign is the XOR of the operand signs. The significand is rounded to nearest, with ties going to the even value, at WMAN fraction bits. `err` is low.
- R3: A normal request accepted on clock edge k makes `done` high for exactly one cycle after edge k+WMAN+4. `busy` is high after edges k through k+WMAN+3 and is never high together with `done`.
- R4: A request with a zero or infinite operand makes `done` high for one cycle right after the accepting edge, and `busy` stays low.
- R5: 0/0 and ±inf/±inf return +0 with `err` high.
- R6: A nonzero dividend (finite or infinite) divided by zero returns infinity carrying the dividend's sign only, with `err` high.
- R7: A finite dividend divided by ±inf returns +0. A zero dividend divided by a finite nonzero divisor returns +0. In both cases `err` is low.
- R8: ±inf divided by a finite nonzero value returns infinity with the XOR sign and `err` low.
- R9: A rounded quotient below min_normal/2 returns +0. One in [min_normal/2, min_normal) returns the minimum normal value (exponent 1, fraction 0) with the XOR sign.
- R10: A rounded quotient whose exponent would reach the all-ones field returns infinity with the XOR sign and `err` low.
- R11: `start` is ignored while `busy` is high. The operands and the completion time of the running division are unaffected, and no extra `done` follows.
- R12: `quotient` and `err` hold their values between `done` pulses. After reset they are 0, and so are `done` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when not busy |
| dividend | input | W | Numerator operand |
| divisor | input | W | Denominator operand |
| busy | output | 1 | Significand iteration or rounding in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | W | Result, held until the next completion |
| err | output | 1 | Set with a result for zero divisors and inf/inf |

## Verification
A stuck or miscounted iteration counter shows at the ports on the very first ordinary division: `done` arrives on the wrong edge, or never arrives, and the latency check catches this within about WMAN+5 cycles. A remainder or quotient register that drifts by even one bit changes the rounded fraction or the round-up decision, so a mismatch appears in the same completed quotient. Random operands exercise both normalisation branches and the tie-breaking cases. A wrong special-case decision shows as a wrong sign, a wrong zero/infinity choice or a wrong `err` value one cycle after `start`.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ITER  = 2'd1,
    ST_ROUND = 2'd2
  } fdiv_state_e;
endpackage

// File: rtl/fdiv_classify.sv
// Operand decode: special-value table and setup for the significand divider.
module fdiv_classify #(
  parameter int WEXP = 6,
  parameter int WMAN = 18,
  localparam int W   = 1 + WEXP + WMAN,
  localparam int WE2 = WEXP + 2
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic           special,
  output logic [W-1:0]   spec_res,
  output logic           spec_err,
  output logic           sign_x,
  output logic [WMAN:0]  sig_a,
  output logic [WMAN:0]  sig_b,
  output logic [WE2-1:0] exp_diff
);
  localparam int BIAS = (1 << (WEXP - 1)) - 1;

  logic [WEXP-1:0] exa, exb;
  logic a_zero, a_inf, b_zero, b_inf;

  always_comb begin
    exa    = opa[W-2 -: WEXP];
    exb    = opb[W-2 -: WEXP];
    a_zero = (exa == '0);
    a_inf  = (exa == '1);
    b_zero = (exb == '0);
    b_inf  = (exb == '1);
    sign_x = opa[W-1] ^ opb[W-1];
    sig_a  = {1'b1, opa[WMAN-1:0]};
    sig_b  = {1'b1, opb[WMAN-1:0]};
    exp_diff = WE2'(exa) - WE2'(exb) + WE2'(BIAS);

    special  = a_zero | a_inf | b_zero | b_inf;
    spec_res = '0;
    spec_err = 1'b0;
    if (b_zero) begin
      spec_err = 1'b1;
      if (!a_zero) spec_res = {opa[W-1], {WEXP{1'b1}}, {WMAN{1'b0}}};
    end else if (b_inf) begin
      spec_err = a_inf;
    end else if (a_inf) begin
      spec_res = {sign_x, {WEXP{1'b1}}, {WMAN{1'b0}}};
    end
  end
endmodule

// File: rtl/fdiv_sigdiv.sv
// Restoring radix-2 significand divider, one quotient bit per step.
module fdiv_sigdiv #(
  parameter int WMAN = 18,
  parameter int NQ   = WMAN + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [WMAN:0] num,
  input  logic [WMAN:0] den,
  output logic [NQ-1:0] qbits,
  output logic          rem_nz
);
  logic [WMAN+1:0] rem;
  logic [WMAN:0]   dvs;
  logic [WMAN+1:0] trial;
  logic            fits;

  always_comb begin
    fits  = rem >= {1'b0, dvs};
    trial = rem - {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dvs   <= '0;
      qbits <= '0;
    end else if (load) begin
      rem   <= {1'b0, num};
      dvs   <= den;
      qbits <= '0;
    end else if (step) begin
      qbits <= {qbits[NQ-2:0], fits};
      rem   <= fits ? {trial[WMAN:0], 1'b0} : {rem[WMAN:0], 1'b0};
    end
  end

  assign rem_nz = |rem;

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (rem < {dvs, 1'b0}));

  // R2
  hidden_bit_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> dvs[WMAN]);
endmodule

// File: rtl/fdiv_round.sv
// Normalise, round to nearest even, and map range limits.
module fdiv_round #(
  parameter int WEXP = 6,
  parameter int WMAN = 18,
  localparam int W   = 1 + WEXP + WMAN,
  localparam int WE2 = WEXP + 2,
  localparam int NQ  = WMAN + 3
) (
  input  logic [NQ-1:0]  qbits,
  input  logic           rem_nz,
  input  logic [WE2-1:0] exp_diff,
  input  logic           sign_x,
  output logic [W-1:0]   result
);
  localparam int EMAX = (1 << WEXP) - 1;

  logic [WMAN:0]   sig;
  logic            rbit, sticky, rup;
  logic [WMAN+1:0] rsum;
  logic [WE2-1:0]  e_n, e_r;
  logic [WMAN-1:0] frac;

  always_comb begin
    if (qbits[NQ-1]) begin
      sig    = qbits[NQ-1:2];
      rbit   = qbits[1];
      sticky = qbits[0] | rem_nz;
      e_n    = exp_diff;
    end else begin
      sig    = qbits[NQ-2:1];
      rbit   = qbits[0];
      sticky = rem_nz;
      e_n    = exp_diff - WE2'(1);
    end
    rup  = rbit & (sticky | sig[0]);
    rsum = {1'b0, sig} + {{(WMAN+1){1'b0}}, rup};
    if (rsum[WMAN+1]) begin
      e_r  = e_n + WE2'(1);
      frac = '0;
    end else begin
      e_r  = e_n;
      frac = rsum[WMAN-1:0];
    end

    if (int'($signed(e_r)) >= EMAX)
      result = {sign_x, {WEXP{1'b1}}, {WMAN{1'b0}}};
    else if (int'($signed(e_r)) >= 1)
      result = {sign_x, e_r[WEXP-1:0], frac};
    else if (e_r == '0)
      result = {sign_x, WEXP'(1), {WMAN{1'b0}}};
    else
      result = '0;
  end
endmodule

// File: rtl/fdiv_iter.sv
// Multi-cycle floating-point divider, top level.
module fdiv_iter
  import fdiv_pkg::*;
#(
  parameter int WEXP = 6,
  parameter int WMAN = 18,
  localparam int W   = 1 + WEXP + WMAN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         err
);
  localparam int WE2 = WEXP + 2;
  localparam int NQ  = WMAN + 3;
  localparam int CW  = $clog2(NQ + 1);

  fdiv_state_e    state;
  logic [CW-1:0]  cnt;
  logic           sign_r;
  logic [WE2-1:0] ediff_r;

  logic           special, spec_err, sign_c;
  logic [W-1:0]   spec_res, rnd_res;
  logic [WMAN:0]  sig_a, sig_b;
  logic [WE2-1:0] ediff_c;
  logic [NQ-1:0]  qbits;
  logic           rem_nz;
  logic           accept;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  fdiv_classify #(.WEXP(WEXP), .WMAN(WMAN)) u_cls (
    .opa(dividend), .opb(divisor), .special(special), .spec_res(spec_res),
    .spec_err(spec_err), .sign_x(sign_c), .sig_a(sig_a), .sig_b(sig_b),
    .exp_diff(ediff_c)
  );

  fdiv_sigdiv #(.WMAN(WMAN), .NQ(NQ)) u_sig (
    .clk(clk), .rst(rst), .load(accept && !special),
    .step(state == ST_ITER), .num(sig_a), .den(sig_b),
    .qbits(qbits), .rem_nz(rem_nz)
  );

  fdiv_round #(.WEXP(WEXP), .WMAN(WMAN)) u_rnd (
    .qbits(qbits), .rem_nz(rem_nz), .exp_diff(ediff_r),
    .sign_x(sign_r), .result(rnd_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sign_r   <= 1'b0;
      ediff_r  <= '0;
      quotient <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (special) begin
            quotient <= spec_res;
            err      <= spec_err;
            done     <= 1'b1;
          end else begin
            sign_r  <= sign_c;
            ediff_r <= ediff_c;
            cnt     <= '0;
            state   <= ST_ITER;
          end
        end
        ST_ITER: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(NQ - 1)) state <= ST_ROUND;
        end
        ST_ROUND: begin
          quotient <= rnd_res;
          err      <= 1'b0;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11
  iter_progress_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ITER && cnt != CW'(NQ - 1)) |=> (state == ST_ITER && cnt == $past(cnt) + CW'(1)));

  // R1
  canon_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && quotient[W-2 -: WEXP] == '0) |-> (quotient == '0));

  // R1
  inf_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (done && quotient[W-2 -: WEXP] == '1) |-> (quotient[WMAN-1:0] == '0));

  // R5
  err_value_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (quotient[W-2 -: WEXP] == '0 || quotient[W-2 -: WEXP] == '1));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> (!done || $stable(quotient) || $past(busy) || $past(start)));
endmodule

// File: tb/fdiv_iter_tb.sv
`timescale 1ns/1ps
module fdiv_iter_tb;
  localparam int WEXP = 6;
  localparam int WMAN = 18;
  localparam int W    = 1 + WEXP + WMAN;
  localparam int EMAX = (1 << WEXP) - 1;
  localparam int BIAS = (1 << (WEXP - 1)) - 1;
  localparam int LAT_N = WMAN + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, err;
  logic [W-1:0] quotient;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fdiv_iter #(.WEXP(WEXP), .WMAN(WMAN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .err(err)
  );

  function automatic logic [W-1:0] mk(input bit s, input int e, input int f);
    return {s, WEXP'(e), WMAN'(f)};
  endfunction

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] r, output logic e);
    int ea, eb, ex;
    bit sa, sb, sx, rb, st;
    logic [63:0] num, den, qi, rm, sig;
    ea = int'(a[W-2 -: WEXP]); eb = int'(b[W-2 -: WEXP]);
    sa = a[W-1]; sb = b[W-1]; sx = sa ^ sb;
    r = '0; e = 1'b0;
    if (eb == 0) begin
      e = 1'b1;
      if (ea != 0) r = mk(sa, EMAX, 0);
    end else if (eb == EMAX) begin
      e = (ea == EMAX);
    end else if (ea == 0) begin
      r = '0;
    end else if (ea == EMAX) begin
      r = mk(sx, EMAX, 0);
    end else begin
      num = {45'd0, 1'b1, a[WMAN-1:0]} << (WMAN + 2);
      den = {45'd0, 1'b1, b[WMAN-1:0]};
      qi = num / den; rm = num % den;
      ex = ea - eb + BIAS;
      if (qi >= (64'd1 << (WMAN + 2))) begin
        sig = qi >> 2; rb = qi[1]; st = qi[0] | (rm != 0);
      end else begin
        sig = qi >> 1; rb = qi[0]; st = (rm != 0); ex = ex - 1;
      end
      if (rb && (st || sig[0])) sig = sig + 1;
      if (sig == (64'd1 << (WMAN + 1))) begin sig = sig >> 1; ex = ex + 1; end
      if (ex >= EMAX)    r = mk(sx, EMAX, 0);
      else if (ex >= 1)  r = {sx, WEXP'(ex), sig[WMAN-1:0]};
      else if (ex == 0)  r = mk(sx, 1, 0);
      else               r = '0;
    end
  endfunction

  function automatic bit is_spec(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a[W-2 -: WEXP] == '0) || (a[W-2 -: WEXP] == '1) ||
           (b[W-2 -: WEXP] == '0) || (b[W-2 -: WEXP] == '1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] er;
    logic ee;
    int lat;
    bit sp, saw_busy;
    model(a, b, er, ee);
    sp = is_spec(a, b);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; saw_busy = busy;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(quotient == er, req, "quotient", quotient, er);
    check(err == ee, req, "err", W'(err), W'(ee));
    if (sp) begin
      check(lat == 1, "R4", "latency", W'(lat), W'(1));
      check(!saw_busy, "R4", "busy", W'(saw_busy), W'(0));
    end else begin
      check(lat == LAT_N, "R3", "latency", W'(lat), W'(LAT_N));
      check(saw_busy, "R3", "busy", W'(saw_busy), W'(1));
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [W-1:0] rnd_op();
    int k;
    k = int'($urandom % 8);
    if (k == 0) return mk($urandom % 2, 0, int'($urandom));
    if (k == 1) return mk($urandom % 2, EMAX, int'($urandom));
    if (k < 5)  return mk($urandom % 2, 1 + int'($urandom % (EMAX - 1)), int'($urandom));
    return mk($urandom % 2, BIAS - 6 + int'($urandom % 13), int'($urandom));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb2, er;
    logic ee;
    int lat, extra;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(quotient == '0 && !done && !busy && !err, "R12", "reset",
          {quotient[W-1:3], done, busy, err}, '0);

    // R5
    run(mk(0, 0, 0), mk(1, 0, 5), "R5");
    run(mk(1, EMAX, 0), mk(0, EMAX, 3), "R5");
    // R6
    run(mk(0, 33, 100), mk(1, 0, 0), "R6");
    run(mk(1, 20, 7), mk(0, 0, 0), "R6");
    run(mk(1, EMAX, 0), mk(1, 0, 0), "R6");
    // R7
    run(mk(1, 40, 9), mk(0, EMAX, 0), "R7");
    run(mk(1, 0, 0), mk(0, 30, 3), "R7");
    // R8
    run(mk(0, EMAX, 1), mk(1, 31, 2), "R8");
    // R2 normal values
    run(mk(0, BIAS, 0), mk(0, BIAS, 0), "R2");
    run(mk(0, BIAS + 1, 1 << (WMAN - 1)), mk(1, BIAS, 1 << (WMAN - 1)), "R2");
    run(mk(1, BIAS, 0), mk(1, BIAS, 1 << (WMAN - 1)), "R2");
    // R9
    run(mk(0, 1, 1 << (WMAN - 1)), mk(1, BIAS + 1, 0), "R9");
    run(mk(0, 1, 0), mk(0, BIAS + 2, 0), "R9");
    // R10
    run(mk(1, EMAX - 1, 5), mk(0, 1, 0), "R10");

    // R11 start while busy
    ra = mk(0, BIAS + 3, 12345); rb2 = mk(0, BIAS - 2, 777);
    model(ra, rb2, er, ee);
    @(negedge clk);
    dividend = ra; divisor = rb2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    @(negedge clk); lat++;
    dividend = mk(1, 10, 3); divisor = mk(0, 50, 9); start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(quotient == er, "R11", "quotient", quotient, er);
    check(lat == LAT_N, "R11", "latency", W'(lat), W'(LAT_N));
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R11", "extra done", W'(extra), W'(0));
    // R12 hold
    check(quotient == er, "R12", "hold", quotient, er);

    // random mix, R2 for normal pairs
    for (int n = 0; n < 400; n++) begin
      ra = rnd_op(); rb2 = rnd_op();
      run(ra, rb2, "R2");
    end

    summary();
    $finish;
  end
endmodule